// File: doc/BRIEF.md
# Tick counter with compare interrupt

This block keeps a free-running cycle counter and compares it against a programmable value. When the two agree while compare interrupts are enabled, a bit is latched in a soft-interrupt register, and an interrupt request stays high for as long as any bit of that register is set. Software loads the counter, the compare value and the soft-interrupt bits through a single write port. The soft-interrupt register can also be written through two alias selects: one ORs bits in and the other clears them, so that no read-modify-write is needed.

Both 64-bit words carry a control bit above the 63-bit value. In the counter word, bit 63 makes the counter unreadable from unprivileged code. In the compare word, bit 63 masks the interrupt. Reads go through a small response state machine with three states. `RP_IDLE` means no response is pending. `RP_DATA` drives a data response. `RP_FAULT` reports a privilege fault. The machine moves from any state to `RP_IDLE` when no read is requested, to `RP_FAULT` when the request is a protected counter read, and to `RP_DATA` for any other read.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count is 0 with its protect bit (bit 63) at 1, the compare value is 0 with its disable bit (bit 63) at 1, the soft-interrupt register is 0, and `irq` and `rd_valid` are 0.
- R2: When the counter is not written, the count in bits 62:0 increases by one every clock and wraps from all ones to zero.
- R3: A write with select 0 loads bits 62:0 of `wr_data` into the count and bit 63 into the protect bit. Counting resumes from the loaded value on the next clock.
- R4: A write with select 1 loads the compare value (bits 62:0) and the disable bit (bit 63). When the count equals the compare value and the disable bit is 0, bit 0 of the soft-interrupt register is set on the following clock. The protect bit of the counter plays no part in the comparison.
- R5: While the disable bit is 1, an equal count leaves soft-interrupt bit 0 unchanged.
- R6: The soft-interrupt register is 16 bits wide. Bit 0 is the tick match, bits 14:1 are interrupt levels and bit 15 is a second timer match. A write with select 2 replaces all 16 bits. Bits 63:16 of the write are ignored, and those bits read back as 0.
- R7: A write with select 3 ORs `wr_data[15:0]` into the soft-interrupt register. A write with select 4 clears every bit that is set in `wr_data[15:0]`.
- R8: When a compare match and a soft-interrupt write land in the same cycle, the match is applied after the write, so bit 0 ends up 1.
- R9: `irq` is 1 exactly when the soft-interrupt register is non-zero, and it follows the register with no extra delay.
- R10: A read request (`rd_en`) is answered one clock later by a single-cycle `rd_valid`. The response carries the register value from the request cycle. Select 0 returns {protect, count}, select 1 returns {disable, compare}, and selects 2, 3 and 4 return the soft-interrupt register.
- R11: A read with select 0 made while `priv` is 0 and the protect bit is 1 answers with `rd_fault` at 1 and `rd_data` at 0. No other read faults.
- R12: Selects 5 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | CNT_W+1 (64) | Write data |
| rd_en | input | 1 | Read request |
| rd_sel | input | 3 | Read target select |
| priv | input | 1 | Requester is privileged |
| rd_valid | output | 1 | Read response valid |
| rd_fault | output | 1 | Read refused because of privilege |
| rd_data | output | CNT_W+1 (64) | Read response data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 63-bit count and a 16-bit soft-interrupt register. With those widths, loading an all-ones count makes the wrap to zero appear on the very next cycle, so no long wait is needed. Loading a count a few cycles short of the compare value places the match in a known cycle. That lets the bench confirm that no interrupt appears early and that a clear written in the match cycle loses to the match. The same widths exercise the fault path on an unprivileged counter read and the zero upper bits of the soft-interrupt register.

// File: rtl/tick_pkg.sv
package tick_pkg;

    typedef enum logic [2:0] {
        SEL_TICK     = 3'd0,
        SEL_CMP      = 3'd1,
        SEL_SOFT     = 3'd2,
        SEL_SOFT_SET = 3'd3,
        SEL_SOFT_CLR = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        RP_IDLE  = 2'd0,
        RP_DATA  = 2'd1,
        RP_FAULT = 2'd2
    } rd_state_e;

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W:0]   load_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             npt_o
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
            npt_o <= 1'b1;
        end else if (load) begin
            cnt_o <= load_val[CNT_W-1:0];
            npt_o <= load_val[CNT_W];
        end else begin
            cnt_o <= cnt_o + STEP;
        end
    end
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W:0]   load_val,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             dis_o,
    output logic             match_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_o <= '0;
            dis_o <= 1'b1;
        end else if (load) begin
            cmp_o <= load_val[CNT_W-1:0];
            dis_o <= load_val[CNT_W];
        end
    end

    assign match_o = !dis_o && (cnt_i == cmp_o);
endmodule

// File: rtl/softint_reg.sv
module softint_reg #(
    parameter int SI_W    = 16,
    parameter int HIT_BIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_dir,
    input  logic            wr_set,
    input  logic            wr_clr,
    input  logic [SI_W-1:0] wr_val,
    input  logic            tick_hit,
    output logic [SI_W-1:0] bits_q
);
    logic [SI_W-1:0] base_n;
    logic [SI_W-1:0] bits_n;

    for (genvar i = 0; i < SI_W; i++) begin : g_bit
        assign base_n[i] = wr_dir ? wr_val[i] :
                           wr_set ? (bits_q[i] | wr_val[i]) :
                           wr_clr ? (bits_q[i] & ~wr_val[i]) :
                                    bits_q[i];
        if (i == HIT_BIT) begin : g_hit
            assign bits_n[i] = base_n[i] | tick_hit;
        end else begin : g_plain
            assign bits_n[i] = base_n[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_n;
    end
endmodule

// File: rtl/tick_read_port.sv
module tick_read_port
    import tick_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [2:0]       rd_sel,
    input  logic             priv,
    input  logic             npt,
    input  logic [REG_W-1:0] tick_word,
    input  logic [REG_W-1:0] cmp_word,
    input  logic [REG_W-1:0] soft_word,
    output logic             rd_valid,
    output logic             rd_fault,
    output logic [REG_W-1:0] rd_data
);
    rd_state_e        state_q, state_n;
    reg_sel_e         rsel;
    logic             fault_now;
    logic [REG_W-1:0] pick;
    logic [REG_W-1:0] data_q;

    assign rsel      = reg_sel_e'(rd_sel);
    assign fault_now = rd_en && !priv && npt && (rsel == SEL_TICK);

    always_comb begin
        unique case (rsel)
            SEL_TICK:                         pick = tick_word;
            SEL_CMP:                          pick = cmp_word;
            SEL_SOFT, SEL_SOFT_SET, SEL_SOFT_CLR: pick = soft_word;
            default:                          pick = '0;
        endcase
    end

    always_comb begin
        if (!rd_en)         state_n = RP_IDLE;
        else if (fault_now) state_n = RP_FAULT;
        else                state_n = RP_DATA;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_n;
            if (rd_en) data_q <= fault_now ? '0 : pick;
        end
    end

    always_comb begin
        unique case (state_q)
            RP_IDLE: begin
                rd_valid = 1'b0;
                rd_fault = 1'b0;
                rd_data  = '0;
            end
            RP_DATA: begin
                rd_valid = 1'b1;
                rd_fault = 1'b0;
                rd_data  = data_q;
            end
            RP_FAULT: begin
                rd_valid = 1'b1;
                rd_fault = 1'b1;
                rd_data  = '0;
            end
            default: begin
                rd_valid = 1'b0;
                rd_fault = 1'b0;
                rd_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tick_pkg::*;
#(
    parameter int CNT_W = 63,
    parameter int SI_W  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [CNT_W:0] wr_data,
    input  logic           rd_en,
    input  logic [2:0]     rd_sel,
    input  logic           priv,
    output logic           rd_valid,
    output logic           rd_fault,
    output logic [CNT_W:0] rd_data,
    output logic           irq
);
    localparam int REG_W = CNT_W + 1;

    reg_sel_e         wsel;
    logic             wr_tick, wr_cmp, wr_dir, wr_set, wr_clr;
    logic [CNT_W-1:0] cnt_q;
    logic             npt_q;
    logic [CNT_W-1:0] cmp_val;
    logic             cmp_dis;
    logic             tick_hit;
    logic [SI_W-1:0]  soft_q;
    logic [REG_W-1:0] tick_word, cmp_word, soft_word;

    assign wsel    = reg_sel_e'(wr_sel);
    assign wr_tick = wr_en && (wsel == SEL_TICK);
    assign wr_cmp  = wr_en && (wsel == SEL_CMP);
    assign wr_dir  = wr_en && (wsel == SEL_SOFT);
    assign wr_set  = wr_en && (wsel == SEL_SOFT_SET);
    assign wr_clr  = wr_en && (wsel == SEL_SOFT_CLR);

    tick_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .load(wr_tick), .load_val(wr_data),
        .cnt_o(cnt_q), .npt_o(npt_q)
    );

    tick_compare #(.CNT_W(CNT_W)) u_compare (
        .clk(clk), .rst_n(rst_n), .load(wr_cmp), .load_val(wr_data),
        .cnt_i(cnt_q), .cmp_o(cmp_val), .dis_o(cmp_dis), .match_o(tick_hit)
    );

    softint_reg #(.SI_W(SI_W), .HIT_BIT(0)) u_soft (
        .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_set(wr_set),
        .wr_clr(wr_clr), .wr_val(wr_data[SI_W-1:0]), .tick_hit(tick_hit),
        .bits_q(soft_q)
    );

    assign tick_word = {npt_q, cnt_q};
    assign cmp_word  = {cmp_dis, cmp_val};
    assign soft_word = {{(REG_W-SI_W){1'b0}}, soft_q};

    tick_read_port #(.REG_W(REG_W)) u_rdport (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .priv(priv),
        .npt(npt_q), .tick_word(tick_word), .cmp_word(cmp_word),
        .soft_word(soft_word), .rd_valid(rd_valid), .rd_fault(rd_fault),
        .rd_data(rd_data)
    );

    assign irq = |soft_q;
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
    parameter int CNT_W = 63,
    parameter int SI_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [CNT_W:0]   wr_data,
    input logic             rd_en,
    input logic             rd_valid,
    input logic             rd_fault,
    input logic [CNT_W:0]   rd_data,
    input logic [CNT_W-1:0] cnt_q,
    input logic             npt_q,
    input logic [CNT_W-1:0] cmp_val,
    input logic             cmp_dis,
    input logic [SI_W-1:0]  soft_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R2: free-running increment with wrap
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr_en) && $past(wr_sel) == 3'd0))
        |-> cnt_q == $past(cnt_q) + ONE);

    // R3: counter load takes the whole word
    a_r3_tick_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_sel) == 3'd0)
        |-> {npt_q, cnt_q} == $past(wr_data));

    // R4 / R8: an enabled match always leaves bit 0 set
    a_r4_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_q == cmp_val) && !$past(cmp_dis))
        |-> soft_q[0]);

    // R5: disabled compare cannot raise bit 0
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmp_dis) && !$past(soft_q[0]) &&
         !($past(wr_en) && ($past(wr_sel) == 3'd2 || $past(wr_sel) == 3'd3)))
        |-> !soft_q[0]);

    // R7: clear alias removes the written bits absent a match
    a_r7_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_sel) == 3'd4 &&
         !($past(cnt_q == cmp_val) && !$past(cmp_dis)))
        |-> (soft_q & $past(wr_data[SI_W-1:0])) == '0);

    // R10: a response only follows a request
    a_r10_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));

    // R11: a fault carries no data
    a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> (rd_valid && rd_data == '0));
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.CNT_W(CNT_W), .SI_W(SI_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_fault(rd_fault), .rd_data(rd_data), .cnt_q(cnt_q), .npt_q(npt_q),
    .cmp_val(cmp_val), .cmp_dis(cmp_dis), .soft_q(soft_q)
);

// File: tb/tick_cmp_timer_bench.sv
module tick_cmp_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 63;
    localparam int SI_W  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_sel = '0;
    logic        priv = 1'b0;
    logic        rd_valid, rd_fault, irq;
    logic [63:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [63:0] exp_d_q[$];
    logic        exp_f_q[$];
    string       exp_t_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_cmp_timer #(.CNT_W(CNT_W), .SI_W(SI_W)) u_tick_cmp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .priv(priv),
        .rd_valid(rd_valid), .rd_fault(rd_fault), .rd_data(rd_data), .irq(irq)
    );

    task automatic do_write(input logic [2:0] sel, input logic [63:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_read(input logic [2:0] sel, input logic p,
                           input logic [63:0] ed, input logic ef, input string tag);
        rd_en = 1'b1; rd_sel = sel; priv = p;
        exp_d_q.push_back(ed); exp_f_q.push_back(ef); exp_t_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0; priv = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_bit(input logic act, input logic e, input string tag);
        n_checks++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, e);
        end
    endtask

    // monitor: pops the scoreboard on every response
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid === 1'b1) begin
                n_checks++;
                if (exp_d_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10 unexpected response: actual data %h expected none", rd_data);
                end else begin
                    logic [63:0] ed;
                    logic        ef;
                    string       tg;
                    ed = exp_d_q.pop_front();
                    ef = exp_f_q.pop_front();
                    tg = exp_t_q.pop_front();
                    if (rd_data !== ed || rd_fault !== ef) begin
                        n_fail++;
                        $display("FAIL %s: actual data %h fault %0b expected data %h fault %0b",
                                 tg, rd_data, rd_fault, ed, ef);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_bit(rd_valid, 1'b0, "R1 rd_valid in reset");
        check_bit(irq, 1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        do_read(3'd0, 1'b1, 64'h8000_0000_0000_0000, 1'b0, "R1 tick reset value");
        do_read(3'd0, 1'b0, 64'h0, 1'b1, "R1 R11 protected tick at reset");
        do_read(3'd1, 1'b0, 64'h8000_0000_0000_0000, 1'b0, "R1 R11 compare reset value");
        do_read(3'd2, 1'b1, 64'h0, 1'b0, "R1 softint reset value");

        // R3 load then R2 counting
        do_write(3'd0, 64'd100);
        do_read(3'd0, 1'b1, 64'd100, 1'b0, "R3 loaded count");
        do_read(3'd0, 1'b0, 64'd101, 1'b0, "R2 R11 next count unprotected");
        idle(1);
        do_read(3'd0, 1'b0, 64'd103, 1'b0, "R2 count after idle");

        // R2 wrap
        do_write(3'd0, 64'h7FFF_FFFF_FFFF_FFFF);
        do_read(3'd0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, "R2 count all ones");
        do_read(3'd0, 1'b1, 64'h0, 1'b0, "R2 wrap to zero");

        // R11 protection
        do_write(3'd0, 64'h8000_0000_0000_0010);
        do_read(3'd0, 1'b0, 64'h0, 1'b1, "R11 protected tick fault");
        do_read(3'd0, 1'b1, 64'h8000_0000_0000_0011, 1'b0, "R11 R3 privileged read");

        // R6 R7 R9 soft-interrupt register
        do_write(3'd2, 64'hFFFF_FFFF_FFFF_1234);
        check_bit(irq, 1'b1, "R9 irq with bits set");
        do_read(3'd2, 1'b0, 64'h1234, 1'b0, "R6 direct write upper bits ignored");
        do_write(3'd4, 64'h1234);
        check_bit(irq, 1'b0, "R9 irq after clear");
        do_write(3'd3, 64'h8004);
        do_write(3'd3, 64'h0010);
        do_read(3'd2, 1'b1, 64'h8014, 1'b0, "R7 set alias ORs");
        do_write(3'd4, 64'h8000);
        do_read(3'd3, 1'b1, 64'h0014, 1'b0, "R7 R10 clear alias via alias select");
        do_write(3'd4, 64'hFFFF);
        check_bit(irq, 1'b0, "R9 irq low when empty");
        do_read(3'd5, 1'b1, 64'h0, 1'b0, "R12 unused select reads zero");
        do_write(3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
        do_read(3'd2, 1'b1, 64'h0, 1'b0, "R12 unused write leaves softint");
        do_read(3'd1, 1'b1, 64'h8000_0000_0000_0000, 1'b0, "R12 unused write leaves compare");

        // R4 match timing, protect bit ignored in compare
        do_write(3'd1, 64'h0000_0000_0000_1000);
        do_write(3'd0, 64'h8000_0000_0000_0FFD);
        check_bit(irq, 1'b0, "R4 no irq right after load");
        idle(3);
        check_bit(irq, 1'b0, "R4 no irq during match cycle");
        idle(1);
        check_bit(irq, 1'b1, "R4 irq after match edge");
        do_read(3'd2, 1'b1, 64'h1, 1'b0, "R4 tick-match bit set");
        do_write(3'd1, 64'h8000_0000_0000_1000);
        do_write(3'd4, 64'h1);
        check_bit(irq, 1'b0, "R9 irq cleared");

        // R5 disabled compare
        do_write(3'd0, 64'h0FFE);
        idle(5);
        check_bit(irq, 1'b0, "R5 disabled compare no irq");
        do_read(3'd2, 1'b1, 64'h0, 1'b0, "R5 softint untouched");

        // R8 match beats a clear in the same cycle
        do_write(3'd1, 64'h0000_0000_0000_2000);
        do_write(3'd3, 64'h0006);
        do_write(3'd0, 64'h1FFE);
        idle(2);
        do_write(3'd4, 64'h0007);
        do_read(3'd2, 1'b1, 64'h1, 1'b0, "R8 match applied after clear");
        do_write(3'd1, 64'h8000_0000_0000_0000);
        do_write(3'd4, 64'hFFFF);

        idle(2);
        n_checks++;
        if (exp_d_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 missing responses: actual %0d pending expected 0", exp_d_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule